// File: doc/BRIEF.md
# Crypto Engine FIFO Sequencer

This block is the control front end of a 128-bit block-cipher engine. Software or a DMA engine talks to it through a small 32-bit register port. Data words written to the data address go into a 16-word input queue. The sequencer groups them four at a time into 128-bit blocks and hands each block to the cipher over a request/response port, or copies it unchanged in the pass-through modes. Each result goes into a 16-word output queue, which is drained by reads of the same data address.

A transfer starts when the run bit rises. At that edge the remaining-block counter loads from the upper half of the block-count register. The block raises a request line toward each DMA direction according to two programmable thresholds. When the last block is done, the run bit drops by itself and an optional one-cycle interrupt pulse is produced. Key storage and the cipher transform live elsewhere.

Top module: `crypto_fifo_seq`

## Requirements
- R1: Each queue holds 16 words of 32 bits. A control read returns the stored control bits OR-ed with the input queue level in bits [4:0] and the output queue level in bits [9:5].
- R2: A control write keeps only the bits under mask 0xFC1FF000. A 1 written to bit 10 empties the input queue and a 1 written to bit 11 empties the output queue. Neither flush bit is stored.
- R3: The output threshold is 4, 8, 12 or 16 words for bits [15:14] = 0, 1, 2 or 3. `dma_out_req` is high exactly when the output level is at or above that threshold.
- R4: The input threshold uses bits [13:12] in reverse order: 0 selects 16 words and 3 selects 4 words. `dma_in_req` is high exactly when run bit 31 is set and the number of free input words is at or above that threshold.
- R5: The remaining-block counter loads from block-count bits [31:16] only when a control write takes bit 31 from 0 to 1. A write that finds bit 31 already set does not reload it.
- R6: While bit 31 is set, a block starts when the input level is at least 4, the remaining count is nonzero and the output queue has at least 4 free words. The first word written becomes block bits [31:0] and the fourth becomes bits [127:96]. Each finished block lowers the count by one.
- R7: Mode bits [29:28] = 2 or 3 send blocks through the cipher port. Modes 0 and 1 copy each block unchanged into the output queue, in the same word order.
- R8: When the remaining count is 0 while running, bit 31 clears itself. If bit 30 is set, `irq` pulses for one cycle. This also holds for a start with a block count of 0.
- R9: A data write to a full input queue is dropped. A data read from an empty output queue leaves `reg_rdata` unchanged. Neither changes any level.
- R10: `cph_req_valid` holds with a stable block until `cph_req_ready`. At most one block is outstanding. The result is taken in the cycle `cph_rsp_valid` is high.
- R11: Reads are registered: `reg_rdata` changes the cycle after `reg_rd_en`. Address 0 is control, 1 is block count (read back as written), 2 is data, and address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 block count, 2 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| dma_in_req | output | 1 | Input queue can take a threshold-sized burst |
| dma_out_req | output | 1 | Output queue holds a threshold-sized burst |
| irq | output | 1 | One-cycle transfer-done pulse |
| cph_req_valid | output | 1 | Block offered to the cipher |
| cph_req_ready | input | 1 | Cipher accepts the block |
| cph_req_block | output | 128 | Block to the cipher |
| cph_rsp_valid | input | 1 | Cipher result present |
| cph_rsp_block | input | 128 | Cipher result |

## Verification
The bench goes after three kinds of corner case.

- Threshold fields. Both threshold fields are swept against every queue level. If the input field were decoded in the same order as the output field, `dma_in_req` would be wrong at every level where the two encodings differ.
- Block counter loading. The block count is rewritten in the middle of a run and the run bit is written again. A counter that reloaded on any write would then process too many blocks and leave the input queue empty instead of holding four words.
- Queue limits. The bench overfills the input queue and reads the output queue while it is empty. A queue that took a seventeenth word would change the data that comes out. A read path that returned stale queue contents would change `reg_rdata` when it should stay put.

A start with a count of zero is also exercised. It must still end the run and raise the interrupt, not leave the run bit stuck high.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int unsigned REG_W = 32;
  localparam logic [REG_W-1:0] CTRL_KEEP = 32'hFC1F_F000;
  localparam int unsigned RUN_BIT    = 31;
  localparam int unsigned IRQEN_BIT  = 30;
  localparam int unsigned MODE_LSB   = 28;
  localparam int unsigned OTHR_LSB   = 14;
  localparam int unsigned ITHR_LSB   = 12;
  localparam int unsigned FLOUT_BIT  = 11;
  localparam int unsigned FLIN_BIT   = 10;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_BLK  = 2'd1;
  localparam logic [1:0] ADR_DATA = 2'd2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PASS = 2'd1,
    SQ_REQ  = 2'd2,
    SQ_RSP  = 2'd3
  } sq_state_e;
endpackage

// File: rtl/cfs_fifo.sv
module cfs_fifo #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned PUSH_N = 1,
  parameter int unsigned POP_N  = 1,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = PTR_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     push_en,
  input  logic [PUSH_N*WORD_W-1:0] push_data,
  input  logic                     pop_en,
  output logic [POP_N*WORD_W-1:0]  pop_data,
  output logic [LVL_W-1:0]         level
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0]  level_q, level_d;
  logic              do_push, do_pop;

  assign do_push = push_en && (level_q <= LVL_W'(DEPTH - PUSH_N));
  assign do_pop  = pop_en && (level_q >= LVL_W'(POP_N));

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      if (do_push) wr_ptr_d = wr_ptr_q + PTR_W'(PUSH_N);
      if (do_pop)  rd_ptr_d = rd_ptr_q + PTR_W'(POP_N);
      level_d = level_q + (do_push ? LVL_W'(PUSH_N) : '0) - (do_pop ? LVL_W'(POP_N) : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) begin
      for (int i = 0; i < int'(PUSH_N); i++) begin
        mem_q[wr_ptr_q + PTR_W'(i)] <= push_data[i*WORD_W +: WORD_W];
      end
    end
  end

  for (genvar g = 0; g < int'(POP_N); g++) begin : g_rd_lane
    assign pop_data[g*WORD_W +: WORD_W] = mem_q[rd_ptr_q + PTR_W'(g)];
  end

  assign level = level_q;

  AST_FIFO_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_W'(DEPTH)); // R1
  AST_FIFO_FULL_PUSH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !pop_en && !flush && level_q > LVL_W'(DEPTH - PUSH_N))
      |=> level_q == $past(level_q)); // R9
  AST_FIFO_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !push_en && !flush && level_q < LVL_W'(POP_N))
      |=> level_q == $past(level_q)); // R9
endmodule

// File: rtl/cfs_regs.sv
module cfs_regs
  import cfs_pkg::*;
#(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic [LVL_W-1:0] in_level,
  input  logic [LVL_W-1:0] out_level,
  input  logic [REG_W-1:0] out_head,
  output logic             in_push,
  output logic             out_pop,
  output logic             flush_in,
  output logic             flush_out,
  output logic             run,
  output logic [1:0]       mode,
  output logic [1:0]       in_code,
  output logic [1:0]       out_code,
  output logic             start,
  output logic [CNT_W-1:0] blk_total,
  input  logic             done,
  output logic             irq
);
  logic [REG_W-1:0] ctrl_q, ctrl_d, blk_q, rdata_q, rdata_d;
  logic             ctrl_wr, ctrl_en, blk_en, irq_q, irq_d;

  assign ctrl_wr = wr_en && (addr == ADR_CTRL);
  assign blk_en  = wr_en && (addr == ADR_BLK);
  assign start   = ctrl_wr && wdata[RUN_BIT] && !ctrl_q[RUN_BIT];
  assign ctrl_en = ctrl_wr || done;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = wdata & CTRL_KEEP;
    if (done && !start) ctrl_d[RUN_BIT] = 1'b0;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      case (addr)
        ADR_CTRL: rdata_d = ctrl_q | REG_W'({out_level, in_level});
        ADR_BLK:  rdata_d = blk_q;
        ADR_DATA: if (out_level != '0) rdata_d = out_head;
        default:  rdata_d = '0;
      endcase
    end
  end

  assign irq_d = done && ctrl_q[IRQEN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      blk_q   <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (blk_en)  blk_q  <= wdata;
      if (rd_en)   rdata_q <= rdata_d;
      irq_q <= irq_d;
    end
  end

  assign in_push   = wr_en && (addr == ADR_DATA);
  assign out_pop   = rd_en && (addr == ADR_DATA);
  assign flush_in  = ctrl_wr && wdata[FLIN_BIT];
  assign flush_out = ctrl_wr && wdata[FLOUT_BIT];
  assign run       = ctrl_q[RUN_BIT];
  assign mode      = ctrl_q[MODE_LSB +: 2];
  assign in_code   = ctrl_q[ITHR_LSB +: 2];
  assign out_code  = ctrl_q[OTHR_LSB +: 2];
  assign blk_total = blk_q[REG_W-1 -: CNT_W];
  assign rdata     = rdata_q;
  assign irq       = irq_q;

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R8
  AST_RUN_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !ctrl_q[RUN_BIT]); // R8
  AST_START_SETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ctrl_q[RUN_BIT]); // R5
endmodule

// File: rtl/cfs_seq.sv
module cfs_seq
  import cfs_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned BLK_WORDS = 4,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned LVL_W     = 5,
  localparam int unsigned BLK_W    = WORD_W * BLK_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       mode,
  input  logic             start,
  input  logic [CNT_W-1:0] blk_total,
  input  logic [LVL_W-1:0] in_level,
  input  logic [LVL_W-1:0] out_level,
  input  logic [BLK_W-1:0] in_blk,
  output logic             in_pop,
  output logic             out_push,
  output logic [BLK_W-1:0] out_blk,
  output logic             cph_req_valid,
  input  logic             cph_req_ready,
  output logic [BLK_W-1:0] cph_req_block,
  input  logic             cph_rsp_valid,
  input  logic [BLK_W-1:0] cph_rsp_block,
  output logic             done
);
  localparam logic [LVL_W-1:0] BLK_LVL = LVL_W'(BLK_WORDS);
  localparam logic [LVL_W-1:0] ROOM    = LVL_W'(DEPTH - BLK_WORDS);

  sq_state_e        st_q, st_d;
  logic [BLK_W-1:0] blk_q;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             can_go, rem_en;

  assign can_go = run && (rem_q != '0) && (in_level >= BLK_LVL) && (out_level <= ROOM);

  always_comb begin
    st_d          = st_q;
    in_pop        = 1'b0;
    out_push      = 1'b0;
    cph_req_valid = 1'b0;
    case (st_q)
      SQ_IDLE: if (can_go) begin
        in_pop = 1'b1;
        st_d   = mode[1] ? SQ_REQ : SQ_PASS;
      end
      SQ_PASS: begin
        out_push = 1'b1;
        st_d     = SQ_IDLE;
      end
      SQ_REQ: begin
        cph_req_valid = 1'b1;
        if (cph_req_ready) st_d = SQ_RSP;
      end
      SQ_RSP: if (cph_rsp_valid) begin
        out_push = 1'b1;
        st_d     = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    rem_d = rem_q;
    if (start)         rem_d = blk_total;
    else if (out_push) rem_d = rem_q - CNT_W'(1);
  end
  assign rem_en = start || out_push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      rem_q <= '0;
    end else begin
      st_q <= st_d;
      if (rem_en) rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_pop) blk_q <= in_blk;
  end

  assign out_blk       = (st_q == SQ_PASS) ? blk_q : cph_rsp_block;
  assign cph_req_block = blk_q;
  assign done          = run && (rem_q == '0) && (st_q == SQ_IDLE);

  AST_REQ_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cph_req_valid && !cph_req_ready) |=> (cph_req_valid && $stable(cph_req_block))); // R10
  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> (out_level <= ROOM)); // R6
  AST_PUSH_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> (rem_q != '0)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

// File: rtl/crypto_fifo_seq.sv
module crypto_fifo_seq
  import cfs_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned BLK_WORDS  = 4,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH) + 1,
  localparam int unsigned BLK_W     = WORD_W * BLK_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              dma_in_req,
  output logic              dma_out_req,
  output logic              irq,
  output logic              cph_req_valid,
  input  logic              cph_req_ready,
  output logic [BLK_W-1:0]  cph_req_block,
  input  logic              cph_rsp_valid,
  input  logic [BLK_W-1:0]  cph_rsp_block
);
  logic             rst_meta_q, rst_sync_q;
  logic [LVL_W-1:0] in_level, out_level, in_free, in_thr, out_thr;
  logic [WORD_W-1:0] out_head;
  logic [BLK_W-1:0] in_blk, out_blk;
  logic             in_push, out_pop, flush_in, flush_out, run, start, done;
  logic             in_pop, out_push;
  logic [1:0]       mode, in_code, out_code;
  logic [CNT_W-1:0] blk_total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cfs_regs #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_q), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .in_level(in_level), .out_level(out_level), .out_head(out_head),
    .in_push(in_push), .out_pop(out_pop), .flush_in(flush_in), .flush_out(flush_out),
    .run(run), .mode(mode), .in_code(in_code), .out_code(out_code),
    .start(start), .blk_total(blk_total), .done(done), .irq(irq)
  );

  cfs_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH), .PUSH_N(1), .POP_N(BLK_WORDS)) u_in_fifo (
    .clk(clk), .rst_n(rst_sync_q), .flush(flush_in),
    .push_en(in_push), .push_data(reg_wdata),
    .pop_en(in_pop), .pop_data(in_blk), .level(in_level)
  );

  cfs_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH), .PUSH_N(BLK_WORDS), .POP_N(1)) u_out_fifo (
    .clk(clk), .rst_n(rst_sync_q), .flush(flush_out),
    .push_en(out_push), .push_data(out_blk),
    .pop_en(out_pop), .pop_data(out_head), .level(out_level)
  );

  cfs_seq #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .DEPTH(FIFO_DEPTH),
            .CNT_W(CNT_W), .LVL_W(LVL_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_q), .run(run), .mode(mode), .start(start),
    .blk_total(blk_total), .in_level(in_level), .out_level(out_level),
    .in_blk(in_blk), .in_pop(in_pop), .out_push(out_push), .out_blk(out_blk),
    .cph_req_valid(cph_req_valid), .cph_req_ready(cph_req_ready),
    .cph_req_block(cph_req_block), .cph_rsp_valid(cph_rsp_valid),
    .cph_rsp_block(cph_rsp_block), .done(done)
  );

  assign out_thr     = LVL_W'({1'b0, out_code} + 3'd1) << 2;
  assign in_thr      = LVL_W'(3'd4 - {1'b0, in_code}) << 2;
  assign in_free     = LVL_W'(FIFO_DEPTH) - in_level;
  assign dma_out_req = out_level >= out_thr;
  assign dma_in_req  = run && (in_free >= in_thr);

  AST_DMA_OUT_QUIET_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (out_level == '0) |-> !dma_out_req); // R3
  AST_DMA_IN_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !run |-> !dma_in_req); // R4
endmodule

// File: tb/crypto_fifo_seq_tb.sv
module crypto_fifo_seq_tb;
  localparam logic [127:0] PAT = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

  logic         clk, rst_n, reg_wr_en, reg_rd_en;
  logic [1:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic         dma_in_req, dma_out_req, irq;
  logic         cph_req_valid, cph_req_ready, cph_rsp_valid;
  logic [127:0] cph_req_block, cph_rsp_block;

  int total = 0, bad = 0, irq_cnt = 0, acc_cnt = 0;
  bit finished = 0;

  crypto_fifo_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_in_req(dma_in_req), .dma_out_req(dma_out_req), .irq(irq),
    .cph_req_valid(cph_req_valid), .cph_req_ready(cph_req_ready),
    .cph_req_block(cph_req_block), .cph_rsp_valid(cph_rsp_valid),
    .cph_rsp_block(cph_rsp_block)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  // cipher model: variable ready delay, result = block XOR PAT
  initial begin
    logic [127:0] held;
    cph_req_ready = 1'b0;
    cph_rsp_valid = 1'b0;
    cph_rsp_block = '0;
    forever begin
      @(negedge clk);
      if (cph_req_valid) begin
        repeat (acc_cnt % 3) @(negedge clk);
        cph_req_ready = 1'b1;
        held = cph_req_block;
        @(negedge clk);
        cph_req_ready = 1'b0;
        acc_cnt++;
        repeat (acc_cnt % 2 + 1) @(negedge clk);
        cph_rsp_block = held ^ PAT;
        cph_rsp_valid = 1'b1;
        @(negedge clk);
        cph_rsp_valid = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, last, exp;
    int irq0, acc0;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_rd_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(!dma_out_req && !dma_in_req && !irq, "R3 reset outputs", {29'd0, dma_out_req, dma_in_req, irq}, 32'd0);
    rd(2'd0, v); chk(v == 32'd0, "R1 reset ctrl", v, 32'd0);

    // R2 mask and R11 readback
    wr(2'd0, 32'h7FFF_FFFF);
    rd(2'd0, v); chk(v == 32'h7C1F_F000, "R2 keep mask", v, 32'h7C1F_F000);
    chk(!dma_in_req, "R4 no in req when idle", {31'd0, dma_in_req}, 32'd0);
    wr(2'd0, 32'd0);
    wr(2'd1, 32'hABCD_1234);
    rd(2'd1, v); chk(v == 32'hABCD_1234, "R11 blkcnt readback", v, 32'hABCD_1234);
    rd(2'd3, v); chk(v == 32'd0, "R11 addr3 zero", v, 32'd0);

    // R2 flush input
    for (int i = 0; i < 3; i++) wr(2'd2, 32'h55 + i);
    rd(2'd0, v); chk(v == 32'd3, "R1 input level", v, 32'd3);
    wr(2'd0, 32'h0000_0400);
    rd(2'd0, v); chk(v == 32'd0, "R2 flush input not stored", v, 32'd0);

    // R9 overfill input, then pass 4 blocks
    for (int i = 0; i < 18; i++) wr(2'd2, 32'd100 + i);
    rd(2'd0, v); chk(v == 32'd16, "R9 input capped", v, 32'd16);
    wr(2'd1, 32'h0004_0000);
    wr(2'd0, 32'h8000_0000);
    repeat (40) @(negedge clk);
    rd(2'd0, v); chk(v == 32'h200, "R6 four blocks to output", v, 32'h200);
    // R3 sweep every output level and code while draining
    for (int lvl = 16; lvl >= 0; lvl--) begin
      for (int c = 0; c < 4; c++) begin
        wr(2'd0, 32'(c) << 14);
        chk(dma_out_req == (lvl >= (c + 1) * 4), "R3 out threshold", {31'd0, dma_out_req}, 32'(lvl >= (c + 1) * 4));
      end
      if (lvl > 0) begin
        rd(2'd2, v); exp = 32'd100 + 32'(16 - lvl);
        chk(v == exp, "R9 overfill dropped late words", v, exp);
        last = v;
      end
    end
    rd(2'd2, v); chk(v == last, "R9 empty read holds", v, last);
    rd(2'd0, v); chk(v == 32'h0000_C000, "R9 levels zero", v, 32'h0000_C000);

    // R7 / R8 / R10 mode and size sweep
    for (int m = 0; m < 4; m++) begin
      for (int n = 1; n <= 3; n++) begin
        irq0 = irq_cnt; acc0 = acc_cnt;
        wr(2'd1, 32'(n) << 16);
        wr(2'd0, 32'hC000_0000 | (32'(m) << 28));
        for (int j = 0; j < 4 * n; j++) wr(2'd2, 32'hA000_0000 | (32'(m) << 12) | (32'(n) << 8) | 32'(j));
        repeat (60) @(negedge clk);
        exp = 32'h4000_0000 | (32'(m) << 28) | (32'(4 * n) << 5);
        rd(2'd0, v); chk(v == exp, "R8 run cleared and level", v, exp);
        chk(irq_cnt == irq0 + 1, "R8 one irq pulse", 32'(irq_cnt - irq0), 32'd1);
        chk(acc_cnt - acc0 == ((m >= 2) ? n : 0), "R10 cipher accepts", 32'(acc_cnt - acc0), 32'((m >= 2) ? n : 0));
        for (int j = 0; j < 4 * n; j++) begin
          rd(2'd2, v);
          exp = 32'hA000_0000 | (32'(m) << 12) | (32'(n) << 8) | 32'(j);
          if (m >= 2) exp = exp ^ PAT[32 * (j % 4) +: 32];
          chk(v == exp, "R7 block data and order", v, exp);
          last = v;
        end
        rd(2'd2, v); chk(v == last, "R9 empty read after run", v, last);
      end
    end

    // R5 no reload while running
    irq0 = irq_cnt;
    wr(2'd1, 32'h0002_0000);
    wr(2'd0, 32'h8000_0000);
    wr(2'd1, 32'h0005_0000);
    wr(2'd0, 32'h8000_0000);
    for (int j = 0; j < 12; j++) wr(2'd2, 32'h300 + j);
    repeat (40) @(negedge clk);
    rd(2'd0, v); chk(v == 32'h0000_0104, "R5 count latched at rise only", v, 32'h0000_0104);
    chk(irq_cnt == irq0, "R8 no irq without enable", 32'(irq_cnt - irq0), 32'd0);
    wr(2'd0, 32'h0000_0C00);
    rd(2'd0, v); chk(v == 32'd0, "R2 flush both", v, 32'd0);

    // R8 zero count start
    irq0 = irq_cnt;
    wr(2'd1, 32'h0000_FFFF);
    wr(2'd0, 32'hC000_0000);
    repeat (5) @(negedge clk);
    rd(2'd0, v); chk(v == 32'h4000_0000, "R8 zero count ends", v, 32'h4000_0000);
    chk(irq_cnt == irq0 + 1, "R8 zero count irq", 32'(irq_cnt - irq0), 32'd1);

    // R4 input threshold sweep with output stalled full
    wr(2'd1, 32'h0014_0000);
    wr(2'd0, 32'h8000_0000);
    for (int j = 0; j < 16; j++) wr(2'd2, 32'h400 + j);
    repeat (20) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      for (int c = 0; c < 4; c++) begin
        wr(2'd0, 32'h8000_0000 | (32'(c) << 12));
        chk(dma_in_req == ((16 - k) >= (4 - c) * 4), "R4 in threshold", {31'd0, dma_in_req}, 32'((16 - k) >= (4 - c) * 4));
      end
      wr(2'd2, 32'h500 + k);
    end
    rd(2'd0, v); chk(v == 32'h8000_3210, "R6 stalls on full output", v, 32'h8000_3210);
    wr(2'd0, 32'h0000_0C00);
    rd(2'd0, v); chk(v == 32'd0, "R2 cancel and flush", v, 32'd0);

    finish_run();
  end
endmodule